// File: doc/BRIEF.md
# Ring Hop Link Stage

This block is the link-level forwarding stage of one node on a one-way ring. Messages arrive from the previous node into a small input buffer. Each message carries a source node number, a destination node number and a payload. From the head of that buffer the stage does one of three things. It hands the message to the local core if this node is the destination. It discards the message if this node sent it and it has come all the way round. Otherwise it passes the message on to the next node. The local core can also put new messages onto the ring through a valid/ready port. This is allowed only when nothing from the previous node is waiting in the buffer.

Flow control on each link uses credits. The stage holds one credit for each free slot of the next node's input buffer, and sends only while it has a credit. It returns one credit to the previous node for every slot it frees. Forwarded traffic always wins over local injection. Together with at least two slots per link, this keeps a free slot somewhere on the ring, so the ring cannot deadlock and needs no fairness logic. A global stall input freezes every routing decision. While it is high, nothing is removed, sent, injected or credited.

Top module: `ring_link_stage`

## Requirements
- R1: Reset is synchronous and active high. After reset the successor and delivery valids and the upstream credit output are low, and the send credit count equals BUF_DEPTH (2 by default).
- R2: A buffered message whose destination field differs from NODE_ID and whose source field differs from NODE_ID appears on the successor port with all fields unchanged. This happens two cycles after the cycle in which it was presented on the predecessor port, provided the buffer was empty and a credit was held.
- R3: A buffered message whose destination field equals NODE_ID appears on the delivery port with its source and payload. It does not appear on the successor port. The delivery valid is high for exactly one cycle.
- R4: A buffered message whose source field equals NODE_ID and whose destination field differs from NODE_ID is discarded. It appears on neither output port.
- R5: The upstream credit output is high for one cycle in each cycle in which a message leaves the input buffer (forwarded, delivered or discarded), and is low in every other cycle.
- R6: The send credit count starts at BUF_DEPTH. It falls by one for each message sent and rises by one for each cycle in which the downstream credit input is high. No message is sent while the count is zero.
- R7: The inject ready output is high only when the input buffer is empty, a credit is held and stall is low. A buffered predecessor message always takes the link before local injection.
- R8: An accepted injection (valid and ready high in the same cycle) appears on the successor port in the next cycle. Its source field is NODE_ID, and its destination and payload are as injected.
- R9: While stall is high, no message leaves the buffer, none is sent or delivered, no injection is accepted and no credit is returned. Messages arriving from the predecessor are still captured into free slots.
- R10: Messages leave the input buffer in the order in which they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Global freeze of all routing decisions |
| up_valid_i | input | 1 | Message present from predecessor |
| up_src_i | input | ID_W | Source node of incoming message |
| up_dst_i | input | ID_W | Destination node of incoming message |
| up_data_i | input | DATA_W | Payload of incoming message |
| up_credit_o | output | 1 | One credit returned to predecessor |
| dn_valid_o | output | 1 | Message sent to successor (registered) |
| dn_src_o | output | ID_W | Source node of outgoing message |
| dn_dst_o | output | ID_W | Destination node of outgoing message |
| dn_data_o | output | DATA_W | Payload of outgoing message |
| dn_credit_i | input | 1 | One credit returned by successor |
| inj_valid_i | input | 1 | Local core offers a message |
| inj_ready_o | output | 1 | Stage accepts the offered message this cycle |
| inj_dst_i | input | ID_W | Destination node of injected message |
| inj_data_i | input | DATA_W | Payload of injected message |
| dlv_valid_o | output | 1 | Message delivered to local core (registered) |
| dlv_src_o | output | ID_W | Source node of delivered message |
| dlv_data_o | output | DATA_W | Payload of delivered message |

## Verification
Two pairs of events can fall in the same clock cycle. A slot can be freed at the buffer head while a new message is written at the tail. The send counter can also lose a credit to an outgoing message while a returned credit from the successor arrives. Both are provoked by mixed random traffic in which the successor returns each credit one cycle after the send and the predecessor pushes whenever it holds a credit. A behavioural queue model predicts, on every cycle, the credit pulse, the inject ready and both registered output ports, so a miscounted credit or a lost slot shows up as a mismatch in the cycle where it happens.

// File: rtl/ring_link_pkg.sv
package ring_link_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FWD,
    ACT_DLV,
    ACT_DROP,
    ACT_INJ
  } ring_act_e;
endpackage

// File: rtl/ring_link_fifo.sv
module ring_link_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  assign rdata = mem[rp];
  assign empty = (occ == '0);
endmodule

// File: rtl/ring_credit_ctr.sv
module ring_credit_ctr #(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       take,
  input  logic                       give,
  output logic                       avail,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (rst) count <= CNT_W'(DEPTH);
    else     count <= count + CNT_W'(give) - CNT_W'(take);
  end

  assign avail = (count != '0);
endmodule

// File: rtl/ring_link_arb.sv
module ring_link_arb
  import ring_link_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int NODE_ID = 1
) (
  input  logic            stall,
  input  logic            head_ok,
  input  logic [ID_W-1:0] head_src,
  input  logic [ID_W-1:0] head_dst,
  input  logic            cred_ok,
  input  logic            inj_valid,
  output ring_act_e       act,
  output logic            inj_ready
);
  localparam logic [ID_W-1:0] ME = ID_W'(NODE_ID);

  always_comb begin
    act = ACT_NONE;
    if (!stall) begin
      if (head_ok) begin
        if (head_dst == ME)      act = ACT_DLV;
        else if (head_src == ME) act = ACT_DROP;
        else if (cred_ok)        act = ACT_FWD;
      end else if (inj_valid && cred_ok) begin
        act = ACT_INJ;
      end
    end
  end

  assign inj_ready = !stall && !head_ok && cred_ok;
endmodule

// File: rtl/ring_link_stage.sv
module ring_link_stage
  import ring_link_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int NODE_ID   = 1,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 2,
  localparam int ID_W     = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              up_valid_i,
  input  logic [ID_W-1:0]   up_src_i,
  input  logic [ID_W-1:0]   up_dst_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_credit_o,
  output logic              dn_valid_o,
  output logic [ID_W-1:0]   dn_src_o,
  output logic [ID_W-1:0]   dn_dst_o,
  output logic [DATA_W-1:0] dn_data_o,
  input  logic              dn_credit_i,
  input  logic              inj_valid_i,
  output logic              inj_ready_o,
  input  logic [ID_W-1:0]   inj_dst_i,
  input  logic [DATA_W-1:0] inj_data_i,
  output logic              dlv_valid_o,
  output logic [ID_W-1:0]   dlv_src_o,
  output logic [DATA_W-1:0] dlv_data_o
);
  localparam int MSG_W = 2*ID_W + DATA_W;
  localparam int CNT_W = $clog2(BUF_DEPTH+1);

  logic [MSG_W-1:0]  head;
  logic              empty;
  logic [CNT_W-1:0]  occ;
  logic [CNT_W-1:0]  cred;
  logic              cred_ok;
  logic              pop, send;
  ring_act_e         act;
  logic [ID_W-1:0]   h_src, h_dst;
  logic [DATA_W-1:0] h_data;

  assign {h_src, h_dst, h_data} = head;

  ring_link_fifo #(.W(MSG_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .push  (up_valid_i),
    .wdata ({up_src_i, up_dst_i, up_data_i}),
    .pop   (pop),
    .rdata (head),
    .empty (empty),
    .occ   (occ)
  );

  ring_link_arb #(.ID_W(ID_W), .NODE_ID(NODE_ID)) u_arb (
    .stall     (stall_i),
    .head_ok   (!empty),
    .head_src  (h_src),
    .head_dst  (h_dst),
    .cred_ok   (cred_ok),
    .inj_valid (inj_valid_i),
    .act       (act),
    .inj_ready (inj_ready_o)
  );

  ring_credit_ctr #(.DEPTH(BUF_DEPTH)) u_cred (
    .clk   (clk),
    .rst   (rst),
    .take  (send),
    .give  (dn_credit_i),
    .avail (cred_ok),
    .count (cred)
  );

  assign pop         = (act == ACT_FWD) || (act == ACT_DLV) || (act == ACT_DROP);
  assign send        = (act == ACT_FWD) || (act == ACT_INJ);
  assign up_credit_o = pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid_o  <= 1'b0;
      dlv_valid_o <= 1'b0;
    end else begin
      dn_valid_o  <= send;
      dlv_valid_o <= (act == ACT_DLV);
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_INJ) begin
      dn_src_o  <= ID_W'(NODE_ID);
      dn_dst_o  <= inj_dst_i;
      dn_data_o <= inj_data_i;
    end else if (act == ACT_FWD) begin
      dn_src_o  <= h_src;
      dn_dst_o  <= h_dst;
      dn_data_o <= h_data;
    end
    if (act == ACT_DLV) begin
      dlv_src_o  <= h_src;
      dlv_data_o <= h_data;
    end
  end
endmodule

// File: rtl/ring_link_stage_chk.sv
module ring_link_stage_chk #(
  parameter int DEPTH   = 2,
  parameter int NODE_ID = 1,
  parameter int ID_W    = 2,
  parameter int CNT_W   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_i,
  input logic             inj_valid_i,
  input logic             inj_ready_o,
  input logic             up_credit_o,
  input logic             dn_valid_o,
  input logic [ID_W-1:0]  dn_src_o,
  input logic [CNT_W-1:0] occ,
  input logic [CNT_W-1:0] cred
);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));
  p_credit_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cred <= CNT_W'(DEPTH));
  p_send_needs_credit_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid_o) |-> $past(cred) != '0);
  p_credit_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
    up_credit_o |-> occ != '0);
  p_stall_no_inject_r9: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !inj_ready_o);
  p_stall_no_credit_r9: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> !up_credit_o);
  p_inject_empty_r7: assert property (@(posedge clk) disable iff (rst)
    inj_ready_o |-> occ == '0);
  p_own_src_injected_r8: assert property (@(posedge clk) disable iff (rst)
    (inj_valid_i && inj_ready_o) |=> dn_valid_o && dn_src_o == ID_W'(NODE_ID));
endmodule

bind ring_link_stage ring_link_stage_chk #(
  .DEPTH(BUF_DEPTH), .NODE_ID(NODE_ID), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall_i     (stall_i),
  .inj_valid_i (inj_valid_i),
  .inj_ready_o (inj_ready_o),
  .up_credit_o (up_credit_o),
  .dn_valid_o  (dn_valid_o),
  .dn_src_o    (dn_src_o),
  .occ         (occ),
  .cred        (cred)
);

// File: tb/ring_link_stage_test.sv
module ring_link_stage_test;
  localparam int PERIOD = 10;
  localparam int ME     = 1;

  typedef struct packed {
    logic [1:0]  s;
    logic [1:0]  d;
    logic [15:0] x;
  } msg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall_i = 0, up_valid_i = 0, dn_credit_i = 0, inj_valid_i = 0;
  logic [1:0]  up_src_i = 0, up_dst_i = 0, inj_dst_i = 0;
  logic [15:0] up_data_i = 0, inj_data_i = 0;
  logic        up_credit_o, dn_valid_o, inj_ready_o, dlv_valid_o;
  logic [1:0]  dn_src_o, dn_dst_o, dlv_src_o;
  logic [15:0] dn_data_o, dlv_data_o;

  always #(PERIOD/2) clk = ~clk;

  ring_link_stage #(.NODES(4), .NODE_ID(ME), .DATA_W(16), .BUF_DEPTH(2)) uut (
    .clk(clk), .rst(rst), .stall_i(stall_i),
    .up_valid_i(up_valid_i), .up_src_i(up_src_i), .up_dst_i(up_dst_i),
    .up_data_i(up_data_i), .up_credit_o(up_credit_o),
    .dn_valid_o(dn_valid_o), .dn_src_o(dn_src_o), .dn_dst_o(dn_dst_o),
    .dn_data_o(dn_data_o), .dn_credit_i(dn_credit_i),
    .inj_valid_i(inj_valid_i), .inj_ready_o(inj_ready_o),
    .inj_dst_i(inj_dst_i), .inj_data_i(inj_data_i),
    .dlv_valid_o(dlv_valid_o), .dlv_src_o(dlv_src_o), .dlv_data_o(dlv_data_o)
  );

  int   checks = 0, errors = 0;
  msg_t q[$];
  int   cred_m, upc, retq;
  bit   auto_ret;
  bit   e_dn_v, e_dlv_v;
  msg_t e_dn, e_dlv;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit uv, input logic [1:0] us, input logic [1:0] ud,
                      input logic [15:0] ux, input bit iv, input logic [1:0] idst,
                      input logic [15:0] ix, input bit st);
    bit pop, snd, dlv, inj, rdy, ret;
    msg_t h;
    @(negedge clk);
    up_valid_i  = uv && (upc > 0);
    up_src_i    = us; up_dst_i = ud; up_data_i = ux;
    inj_valid_i = iv; inj_dst_i = idst; inj_data_i = ix;
    stall_i     = st;
    ret         = auto_ret && (retq > 0);
    dn_credit_i = ret;
    #1;
    pop = 0; snd = 0; dlv = 0; inj = 0;
    rdy = !st && q.size() == 0 && cred_m > 0;
    if (!st) begin
      if (q.size() > 0) begin
        h = q[0];
        if (h.d == 2'(ME))      begin dlv = 1; pop = 1; end
        else if (h.s == 2'(ME)) pop = 1;
        else if (cred_m > 0)    begin snd = 1; pop = 1; end
      end else if (iv && cred_m > 0) begin
        inj = 1; snd = 1;
      end
    end
    chk(up_credit_o == pop, "R5 credit pulse", up_credit_o, pop);
    chk(inj_ready_o == rdy, "R7 inject ready", inj_ready_o, rdy);
    chk(dn_valid_o == e_dn_v, "R2 successor valid", dn_valid_o, e_dn_v);
    if (e_dn_v && dn_valid_o)
      chk({dn_src_o, dn_dst_o, dn_data_o} == e_dn, "R8 successor fields",
          {dn_src_o, dn_dst_o, dn_data_o}, e_dn);
    chk(dlv_valid_o == e_dlv_v, "R3 delivery valid", dlv_valid_o, e_dlv_v);
    if (e_dlv_v && dlv_valid_o)
      chk({dlv_src_o, dlv_data_o} == {e_dlv.s, e_dlv.x}, "R10 delivery fields",
          {dlv_src_o, dlv_data_o}, {e_dlv.s, e_dlv.x});
    if (dn_valid_o) retq++;
    if (ret) retq--;
    @(posedge clk);
    e_dn_v  = snd;
    e_dlv_v = dlv;
    if (inj)      e_dn = '{s: 2'(ME), d: idst, x: ix};
    else if (snd) e_dn = q[0];
    if (dlv)      e_dlv = q[0];
    if (pop) void'(q.pop_front());
    if (up_valid_i) q.push_back('{s: us, d: ud, x: ux});
    cred_m = cred_m - int'(snd) + int'(ret);
    upc    = upc - int'(up_valid_i) + int'(pop);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cred_m = 2; upc = 2; retq = 0; auto_ret = 1;
    e_dn_v = 0; e_dlv_v = 0; e_dn = '0; e_dlv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: outputs quiet and full credit after reset
    chk(!dn_valid_o && !dlv_valid_o && !up_credit_o, "R1 reset outputs",
        {dn_valid_o, dlv_valid_o, up_credit_o}, 0);
    chk(inj_ready_o, "R1 reset credit", inj_ready_o, 1);
    // R2 forward, R3 deliver, R4 drop
    step(1, 2, 3, 16'hA001, 0, 0, 0, 0); idle(3);
    step(1, 3, 1, 16'hB002, 0, 0, 0, 0); idle(3);
    step(1, 1, 2, 16'hC003, 0, 0, 0, 0); idle(3);
    // R6: credits exhausted by injection, then refilled
    auto_ret = 0;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 2'(i), 16'hD000 + 16'(i), 0);
    chk(inj_ready_o == 0, "R6 no credit blocks send", inj_ready_o, 0);
    auto_ret = 1; idle(4);
    // R7: predecessor traffic beats injection
    for (int i = 0; i < 4; i++) step(1, 0, 3, 16'hE000 + 16'(i), 1, 3, 16'hF000, 0);
    idle(4);
    // R9: stall freezes everything while arrivals are buffered
    step(1, 2, 0, 16'h1111, 1, 0, 16'h2222, 1);
    step(1, 3, 1, 16'h3333, 1, 0, 16'h2222, 1);
    step(0, 0, 0, 0, 1, 0, 16'h2222, 1);
    idle(5);
    // R10: order under back-pressure
    auto_ret = 0;
    for (int i = 0; i < 5; i++) step(1, 2, 0, 16'h4000 + 16'(i), 0, 0, 0, 0);
    auto_ret = 1; idle(8);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) auto_ret = !auto_ret || (i % 100 == 0);
      step(bit'($urandom % 2), 2'($urandom), 2'($urandom), 16'($urandom),
           bit'($urandom % 2), 2'($urandom), 16'($urandom), ($urandom % 7) == 0);
    end
    auto_ret = 1; idle(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule